// File: doc/BRIEF.md
# Pipelined Synchronous Static RAM

This block is a synthesizable behavioural model of a synchronous static RAM with a parameterized number of words. Each word holds two 9-bit byte lanes. Every input except the output enable is captured on the rising clock edge:

- the address and the write data,
- three chip-select inputs,
- two address strobes,
- a global write, a lane write enable and one lane select per byte lane.

Writes are self-timed. The array is updated on the same edge that captures the write, so nothing has to shape a write pulse outside the block.

Reads are pipelined from register to register. A read captured on one edge is looked up in the array on the following edge and loaded into an output register. The output enable is asynchronous and gates that register onto the data output. The data bus itself is modelled as a data-out vector plus a valid flag that stands for the bus being driven rather than at high impedance.

Access sessions are opened only by an address strobe, and the chip selects are examined only on strobe cycles:

- A strobe with the chip enabled starts a session.
- A strobe with the chip disabled ends the session.
- Cycles without a strobe continue the session with the address presented, or do nothing if no session is open.

The host strobe is ignored while the first (active-low) select is high. A host-strobe start is always a read. Burst address generation lives in a separate sequencer block that feeds the address input.

Top module: `psb_sram`

## Requirements
- R1: While reset is active and after it is released, `rvalid` stays 0 until a read has been captured. A cycle without a strobe and with no open session neither reads nor writes.
- R2: A read captured on edge k drives `rdata` with the word at its address after edge k+1, with `rvalid` equal to `!out_en_n`.
- R3: When `wr_all_n` is 0 on a write cycle, both lanes are written, whatever `wr_lane_n` and `lane_sel_n` are.
- R4: With `wr_all_n` 1 and `wr_lane_n` 0, each lane whose `lane_sel_n` bit is 0 is written. Bit 0 selects `wdata[8:0]` and bit 1 selects `wdata[17:9]`. Unselected lanes keep their contents. If both bits are 1, the cycle is a read.
- R5: A read of an address in the cycle right after a write to that address returns the newly written word.
- R6: The chip is enabled only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. The selects have no effect on cycles without a strobe.
- R7: A host strobe (`as_host_n`=0) is ignored when `sel0_n` is 1. With the chip enabled, a host strobe starts a read even when the write inputs request a write.
- R8: A strobe with the chip not enabled deselects it. `rvalid` is 0 after the following edge, and later cycles without a strobe access nothing.
- R9: `out_en_n` acts asynchronously: `rvalid` is 0 whenever it is 1 and follows it at once without waiting for a clock.
- R10: After the edge that follows a captured write, `rvalid` is 0 for that cycle.
- R11: A controller strobe (`as_ctl_n`=0) with the chip enabled starts a write when the write inputs request one, and a read otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| wdata | input | 18 | Write data; lane 0 in bits 8:0, lane 1 in bits 17:9 |
| sel0_n | input | 1 | Active-low chip select; also blocks the host strobe |
| sel1 | input | 1 | Active-high chip select |
| sel2_n | input | 1 | Active-low chip select |
| as_host_n | input | 1 | Host address strobe, active low |
| as_ctl_n | input | 1 | Controller address strobe, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 2 | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data, zero when not driven |
| rvalid | output | 1 | High when the data output is driven |

## Verification
On every cycle, the assertions check the following:

- The output enable masks the output (R9).
- A read drives the output two edges after it is captured, exactly as far as the enable permits (R2).
- Writes and failed strobes leave the output undriven (R8, R10).
- A host strobe from an enabled chip always decodes as a read (R7).
- A global write raises every lane enable (R3).

Only the bench's scenarios can show data correctness: lane masking, write-then-read forwarding through the array, and the session state carried across cycles without a strobe. These are checked against a reference memory over a full fill followed by mixed random traffic.

// File: rtl/psb_pkg.sv
package psb_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_DESEL = 2'd3
    } cyc_e;
endpackage

// File: rtl/psb_decode.sv
module psb_decode
    import psb_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             as_host_n,
    input  logic             as_ctl_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             open_q,
    output cyc_e             cyc,
    output logic [LANES-1:0] lane_we
);
    logic chip_on;
    logic wr_req;
    logic [LANES-1:0] mask;

    always_comb begin
        chip_on = !sel0_n && sel1 && !sel2_n;
        if (!wr_all_n)
            mask = '1;
        else if (!wr_lane_n)
            mask = ~lane_sel_n;
        else
            mask = '0;
        wr_req = |mask;

        if (!as_host_n && !sel0_n)
            cyc = chip_on ? CYC_READ : CYC_DESEL;
        else if (!as_ctl_n)
            cyc = chip_on ? (wr_req ? CYC_WRITE : CYC_READ) : CYC_DESEL;
        else if (open_q)
            cyc = wr_req ? CYC_WRITE : CYC_READ;
        else
            cyc = CYC_IDLE;

        lane_we = (cyc == CYC_WRITE) ? mask : '0;
    end
endmodule

// File: rtl/psb_array.sv
module psb_array #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic [LANES-1:0] lane_we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/psb_outstage.sv
module psb_outstage #(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          out_en_n,
    output logic [AW-1:0] look_addr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic          drive;
        logic [DW-1:0] dout;
    } ost_t;

    ost_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pend  = rd_req;
        st_d.addr  = rd_req ? rd_addr : st_q.addr;
        st_d.drive = st_q.pend;
        if (st_q.pend)
            st_d.dout = arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign look_addr = st_q.addr;
    assign rvalid    = st_q.drive && !out_en_n;
    assign rdata     = rvalid ? st_q.dout : '0;
endmodule

// File: rtl/psb_sram.sv
module psb_sram
    import psb_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             as_host_n,
    input  logic             as_ctl_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             out_en_n,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    typedef struct packed {
        logic open;
    } ses_t;

    ses_t ses_d, ses_q;
    cyc_e cyc_w;
    logic [LANES-1:0] lane_we_w;
    logic [AW-1:0] look_addr_w;
    logic [DW-1:0] arr_rd_w;

    psb_decode #(.LANES(LANES)) u_dec (
        .sel0_n     (sel0_n),
        .sel1       (sel1),
        .sel2_n     (sel2_n),
        .as_host_n  (as_host_n),
        .as_ctl_n   (as_ctl_n),
        .wr_all_n   (wr_all_n),
        .wr_lane_n  (wr_lane_n),
        .lane_sel_n (lane_sel_n),
        .open_q     (ses_q.open),
        .cyc        (cyc_w),
        .lane_we    (lane_we_w)
    );

    always_comb begin
        ses_d      = ses_q;
        ses_d.open = (cyc_w == CYC_READ) || (cyc_w == CYC_WRITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ses_q <= '0;
        else
            ses_q <= ses_d;
    end

    psb_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk     (clk),
        .lane_we (lane_we_w),
        .waddr   (addr),
        .wdata   (wdata),
        .raddr   (look_addr_w),
        .rdata   (arr_rd_w)
    );

    psb_outstage #(.AW(AW), .DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (cyc_w == CYC_READ),
        .rd_addr   (addr),
        .arr_data  (arr_rd_w),
        .out_en_n  (out_en_n),
        .look_addr (look_addr_w),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: rtl/psb_sram_chk.sv
module psb_sram_chk
    import psb_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel0_n,
    input logic             sel1,
    input logic             sel2_n,
    input logic             as_host_n,
    input logic             as_ctl_n,
    input logic             wr_all_n,
    input logic             out_en_n,
    input logic             rvalid,
    input cyc_e             cyc,
    input logic [LANES-1:0] lane_we
);
    logic chip_on;
    assign chip_on = !sel0_n && sel1 && !sel2_n;

    AST_OE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rvalid); // R9
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_READ) |-> ##2 (rvalid == !out_en_n)); // R2
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE) |-> ##2 !rvalid); // R10
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_ctl_n && !chip_on) |-> ##2 !rvalid); // R8
    AST_HOST_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_host_n && chip_on) |-> (cyc == CYC_READ && lane_we == '0)); // R7
    AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE && !wr_all_n) |-> (lane_we == '1)); // R3
endmodule

bind psb_sram psb_sram_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .sel2_n    (sel2_n),
    .as_host_n (as_host_n),
    .as_ctl_n  (as_ctl_n),
    .wr_all_n  (wr_all_n),
    .out_en_n  (out_en_n),
    .rvalid    (rvalid),
    .cyc       (cyc_w),
    .lane_we   (lane_we_w)
);

// File: tb/psb_sram_tb_top.sv
module psb_sram_tb_top;
    localparam int DEPTH = 1024;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [17:0] wdata = '0;
    logic sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic as_host_n = 1'b1, as_ctl_n = 1'b1;
    logic wr_all_n = 1'b1, wr_lane_n = 1'b1;
    logic [1:0] lane_sel_n = 2'b11;
    logic out_en_n = 1'b0;
    logic [17:0] rdata;
    logic rvalid;

    int n_vec = 0;
    int n_bad = 0;
    logic [17:0] ref_mem [DEPTH];
    logic pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    logic ses = 1'b0;
    logic exp_drive = 1'b0;
    logic [17:0] exp_data = '0;

    always #10 clk = ~clk;

    psb_sram #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .as_host_n(as_host_n), .as_ctl_n(as_ctl_n),
        .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .rdata(rdata), .rvalid(rvalid)
    );

    // Cycle kind from the requirements: 0 idle, 1 read, 2 write, 3 deselect
    function automatic int kind_of();
        logic on;
        logic wr;
        on = !sel0_n && sel1 && !sel2_n;
        wr = !wr_all_n || (!wr_lane_n && lane_sel_n != 2'b11);
        if (!as_host_n && !sel0_n) return on ? 1 : 3;          // R7
        if (!as_ctl_n) return on ? (wr ? 2 : 1) : 3;          // R11, R6
        if (ses) return wr ? 2 : 1;
        return 0;                                             // R1
    endfunction

    task automatic model_edge();
        int k;
        logic [1:0] m;
        exp_drive = pend;
        if (pend) exp_data = ref_mem[pend_addr];
        k = kind_of();
        if (k == 2) begin
            m = !wr_all_n ? 2'b11 : ~lane_sel_n;
            if (m[0]) ref_mem[addr][8:0]  = wdata[8:0];
            if (m[1]) ref_mem[addr][17:9] = wdata[17:9];
        end
        pend = (k == 1);
        pend_addr = addr;
        ses = (k == 1) || (k == 2);
    endtask

    task automatic chk(string tag);
        logic ev;
        ev = exp_drive && !out_en_n;
        n_vec++;
        if (rvalid !== ev) begin
            n_bad++;
            $display("FAIL %s rvalid actual=%b expected=%b", tag, rvalid, ev);
        end else if (ev && rdata !== exp_data) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_data);
        end
    endtask

    task automatic chk_val(string tag, logic [17:0] act, logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s value actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag);
    endtask

    task automatic quiet();
        as_host_n = 1; as_ctl_n = 1; wr_all_n = 1; wr_lane_n = 1; lane_sel_n = 2'b11;
    endtask

    task automatic enable();
        sel0_n = 0; sel1 = 1; sel2_n = 0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [17:0] d, logic g, logic w, logic [1:0] b, string tag);
        quiet(); enable(); as_ctl_n = 0; addr = a; wdata = d;
        wr_all_n = g; wr_lane_n = w; lane_sel_n = b;
        tick(tag);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        quiet(); enable(); as_host_n = 0; addr = a;
        tick(tag);
    endtask

    task automatic desel(string tag);
        quiet(); sel0_n = 1; as_ctl_n = 0;
        tick(tag);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        process::self().srandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk("R1");
        rst_n = 1;
        quiet(); sel0_n = 0; sel1 = 1; sel2_n = 0; wr_all_n = 0; addr = 3;
        tick("R1");                   // write request without strobe: idle
        tick("R1");

        for (int i = 0; i < DEPTH; i++)
            wr(AW'(i), 18'($urandom), 1'b0, 1'b1, 2'b11, "R3");
        desel("R8");

        // R3: global write overrides lane selects
        wr(10, 18'h3_1234, 1'b0, 1'b0, 2'b10, "R3");
        rd(10, "R3"); desel("R3");
        chk_val("R3", rdata, 18'h3_1234);

        // R4: lane masking, both lanes
        wr(20, 18'h0_0000, 1'b0, 1'b1, 2'b11, "R4");
        wr(20, 18'h3_FFFF, 1'b1, 1'b0, 2'b10, "R4");
        rd(20, "R4"); desel("R4");
        chk_val("R4", rdata, 18'h0_01FF);
        wr(20, 18'h2_AAAA, 1'b1, 1'b0, 2'b01, "R4");
        rd(20, "R4"); desel("R4");
        chk_val("R4", rdata, {9'h155, 9'h1FF});
        wr(20, 18'h1_5555, 1'b1, 1'b0, 2'b11, "R4");   // both unselected: read
        desel("R4");
        chk_val("R4", rdata, {9'h155, 9'h1FF});

        // R5: write then read next cycle
        wr(33, 18'h1_ABCD, 1'b0, 1'b1, 2'b11, "R5");
        rd(33, "R5"); desel("R5");
        chk_val("R5", rdata, 18'h1_ABCD);

        // R6: selects ignored without a strobe while the session is open
        rd(40, "R6");
        quiet(); sel0_n = 1; sel1 = 0; sel2_n = 1; addr = 41;
        tick("R6"); tick("R6");
        chk_val("R6", rdata, ref_mem[41]);
        desel("R6");
        quiet(); enable(); as_ctl_n = 0; sel1 = 0; addr = 42;
        tick("R6"); tick("R6");

        // R7: host strobe blocked by sel0_n, and never writes
        quiet(); sel0_n = 1; sel1 = 1; sel2_n = 0; as_host_n = 0; addr = 50;
        tick("R7"); tick("R7");
        quiet(); enable(); as_host_n = 0; addr = 51; wr_all_n = 0; wdata = 18'h0_0BAD;
        tick("R7");
        quiet(); as_ctl_n = 0; sel0_n = 1; tick("R7");
        chk_val("R7", rdata, ref_mem[51]);

        // R8: deselect after one cycle, then nothing happens
        rd(60, "R8"); desel("R8");
        quiet(); wr_all_n = 0; addr = 61; wdata = 18'h0_0001;
        tick("R8"); tick("R8");

        // R9: output enable acts without a clock
        rd(70, "R9");
        quiet(); as_ctl_n = 0; sel0_n = 1;
        @(posedge clk); model_edge(); @(negedge clk);
        out_en_n = 1; #1 chk("R9");
        out_en_n = 0; #1 chk("R9");
        chk_val("R9", rdata, ref_mem[70]);

        // R10 / R11: controller strobe write, then output quiet
        wr(80, 18'h2_2222, 1'b0, 1'b1, 2'b11, "R11");
        tick("R10");
        quiet(); enable(); as_ctl_n = 0; addr = 80; tick("R11"); desel("R11");
        chk_val("R11", rdata, 18'h2_2222);

        // R2: random mixed traffic against the reference memory
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            as_host_n  = (r < 2) ? 1'b0 : 1'b1;
            as_ctl_n   = (r >= 2 && r < 5) ? 1'b0 : 1'b1;
            sel0_n     = ($urandom_range(0, 7) == 0);
            sel1       = ($urandom_range(0, 7) != 0);
            sel2_n     = ($urandom_range(0, 7) == 0);
            wr_all_n   = ($urandom_range(0, 4) != 0);
            wr_lane_n  = ($urandom_range(0, 2) != 0);
            lane_sel_n = 2'($urandom);
            addr       = ($urandom_range(0, 1) == 0) ? AW'($urandom_range(0, 7)) : AW'($urandom);
            wdata      = 18'($urandom);
            out_en_n   = ($urandom_range(0, 4) == 0);
            tick("R2");
        end
        out_en_n = 0;
        finish_run();
    end
endmodule